// File: doc/BRIEF.md
# Pulse Dial Relay Sequencer

This block turns a stream of dialing commands into timed transitions on two relay controls. One is the hook relay: 0 means on-hook or the break phase of a dial pulse, and 1 means off-hook or the make phase. The other is the isolation relay: it is 1 while the line is held with extension phones cut off, and 0 while the extensions share the line. A controller opens the line with a go-off-hook command. The block then waits a programmable number of seconds before it accepts dialing. After that it takes decimal digits, pause commands, flash commands and a hang-up command, one at a time.

Each digit becomes a burst of break/make pulses. The pulse rate and the make ratio come from a 2-bit select, which is sampled when the digit is accepted. A fixed 700 ms make interval follows every digit. All timing is counted in strobes of a one-millisecond tick input, so the block stalls whenever the tick stops. A one-cycle done strobe marks the end of every timed command, and the block is ready for the next command in the same cycle.

Top module: `pulse_dial_seq`

## Requirements
- R1: While reset is applied and after it is released, relay_hook and relay_iso are 0, busy and done are 0, and cmd_ready is 1.
- R2: Command code 12 (go off-hook) accepted while on-hook sets both relays to 1 in the next cycle. busy then stays high for predial_s × 1000 tick strobes, and a value of 0 gives a single busy cycle. done pulses for one cycle as busy falls.
- R3: In the off-hook idle state, a digit code 1..9 produces that many break/make pulses on relay_hook, and code 0 produces 10 pulses. Each pulse is a break (0) followed by a make (1).
- R4: rate_sel sets the break/make lengths in ticks: 0 gives 61/39, 1 gives 67/33, 2 gives 33/17, and 3 behaves as 0.
- R5: After the make phase of a digit's last pulse, relay_hook stays 1 for a further 700 ticks. done is then high for one cycle, in the same cycle that cmd_ready returns.
- R6: Command code 10 (pause) keeps relay_hook at 1 and busy high for comma_s × 1000 ticks, and a value of 0 gives a single busy cycle.
- R7: Command code 11 (flash) drives relay_hook to 0 for 500 ticks while relay_iso stays 1, then returns relay_hook to 1.
- R8: Command code 13 (hang up) drives both relays to 0 in the next cycle and leaves the block ready.
- R9: The block accepts and discards a digit, pause or flash issued while on-hook, a repeated go-off-hook while off-hook, and codes 14 and 15. None of these changes the relays or raises busy.
- R10: The rate select is captured when a digit is accepted. Changing rate_sel during that digit has no effect on it.
- R11: Timed phases advance only on cycles where tick_ms is 1. With the tick held low, the current phase holds indefinitely.
- R12: cmd_ready is 1 exactly when busy is 0. A command is taken in a cycle where cmd_valid and cmd_ready are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-millisecond timing strobe |
| cmd_valid | input | 1 | Command present |
| cmd_code | input | 4 | 0..9 digit, 10 pause, 11 flash, 12 off-hook, 13 hang up |
| cmd_ready | output | 1 | Block can take a command |
| rate_sel | input | 2 | Pulse rate / make ratio select |
| predial_s | input | 8 | Seconds to wait after going off-hook |
| comma_s | input | 8 | Seconds of a pause command |
| relay_hook | output | 1 | Hook relay: 1 off-hook/make, 0 on-hook/break |
| relay_iso | output | 1 | Extension isolation relay |
| busy | output | 1 | A timed command is in progress |
| done | output | 1 | One-cycle strobe at the end of a timed command |

## Verification
A wrong pulse counter shows up as one pulse too many or too few on relay_hook. It is visible within about 100 ticks of the digit's expected end, and done moves by a whole pulse period. A mis-decoded state shows up at once as a relay level that contradicts busy or cmd_ready, for example a break during a pause. A timer load error shows up as a phase that differs by a fixed number of ticks on the first break or make. For these reasons the bench measures every low run and high run tick by tick instead of sampling only the end points.

// File: rtl/pd_pkg.sv
package pd_pkg;
  typedef enum logic [2:0] {
    ST_ONHOOK, ST_READY, ST_WAIT, ST_FLASH, ST_BREAK, ST_MAKE, ST_GAP
  } pd_state_e;

  localparam logic [3:0] CODE_MAX_DIGIT = 4'd9;
  localparam logic [3:0] CODE_PAUSE     = 4'd10;
  localparam logic [3:0] CODE_FLASH     = 4'd11;
  localparam logic [3:0] CODE_OFFHOOK   = 4'd12;
  localparam logic [3:0] CODE_HANGUP    = 4'd13;
endpackage

// File: rtl/pd_timer.sv
module pd_timer #(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (tick && (cnt_q != '0));
    cnt_d  = load ? load_val : cnt_q - CNT_W'(1);
    expire = (cnt_q == '0) || (tick && (cnt_q == CNT_W'(1)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_TICK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(cnt_q)); // R11
endmodule

// File: rtl/pd_cadence.sv
module pd_cadence #(
  parameter int CAD_W = 7
) (
  input  logic [1:0]       rate,
  output logic [CAD_W-1:0] brk_ms,
  output logic [CAD_W-1:0] mk_ms
);
  always_comb begin
    case (rate)
      2'd1:    begin mk_ms = CAD_W'(33); brk_ms = CAD_W'(67); end
      2'd2:    begin mk_ms = CAD_W'(17); brk_ms = CAD_W'(33); end
      default: begin mk_ms = CAD_W'(39); brk_ms = CAD_W'(61); end
    endcase
  end
endmodule

// File: rtl/pd_ctrl.sv
module pd_ctrl import pd_pkg::*; #(
  parameter int CNT_W    = 18,
  parameter int SEC_W    = 8,
  parameter int CAD_W    = 7,
  parameter int MS_PER_S = 1000,
  parameter int GAP_MS   = 700,
  parameter int FLASH_MS = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [3:0]       cmd_code,
  output logic             cmd_ready,
  input  logic [1:0]       rate_sel,
  input  logic [SEC_W-1:0] predial_s,
  input  logic [SEC_W-1:0] comma_s,
  input  logic             expire,
  input  logic [CAD_W-1:0] brk_ms,
  input  logic [CAD_W-1:0] mk_ms,
  output logic [1:0]       cad_rate,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             relay_hook,
  output logic             relay_iso,
  output logic             busy,
  output logic             done
);
  localparam logic [CNT_W-1:0] MS_K    = CNT_W'(MS_PER_S);
  localparam logic [CNT_W-1:0] GAP_K   = CNT_W'(GAP_MS);
  localparam logic [CNT_W-1:0] FLASH_K = CNT_W'(FLASH_MS);

  pd_state_e  st_q, st_d;
  logic [3:0] pl_q, pl_d;
  logic [1:0] rate_q, rate_d;
  logic       done_d;
  logic       accept, in_digit;

  always_comb begin
    cmd_ready  = (st_q == ST_ONHOOK) || (st_q == ST_READY);
    busy       = !cmd_ready;
    relay_hook = !((st_q == ST_ONHOOK) || (st_q == ST_BREAK) || (st_q == ST_FLASH));
    relay_iso  = (st_q != ST_ONHOOK);
    in_digit   = (st_q == ST_BREAK) || (st_q == ST_MAKE) || (st_q == ST_GAP);
    cad_rate   = (st_q == ST_READY) ? rate_sel : rate_q;
    accept     = cmd_valid && cmd_ready;
  end

  always_comb begin
    st_d     = st_q;
    pl_d     = pl_q;
    rate_d   = rate_q;
    done_d   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (st_q)
      ST_ONHOOK: begin
        if (accept && cmd_code == CODE_OFFHOOK) begin
          st_d = ST_WAIT; tmr_load = 1'b1;
          tmr_val = CNT_W'(predial_s) * MS_K;
        end
      end
      ST_READY: begin
        if (accept) begin
          if (cmd_code <= CODE_MAX_DIGIT) begin
            st_d = ST_BREAK; tmr_load = 1'b1; tmr_val = CNT_W'(brk_ms);
            pl_d = (cmd_code == 4'd0) ? 4'd10 : cmd_code;
            rate_d = rate_sel;
          end else if (cmd_code == CODE_PAUSE) begin
            st_d = ST_WAIT; tmr_load = 1'b1;
            tmr_val = CNT_W'(comma_s) * MS_K;
          end else if (cmd_code == CODE_FLASH) begin
            st_d = ST_FLASH; tmr_load = 1'b1; tmr_val = FLASH_K;
          end else if (cmd_code == CODE_HANGUP) begin
            st_d = ST_ONHOOK;
          end
        end
      end
      ST_WAIT, ST_FLASH, ST_GAP: begin
        if (expire) begin st_d = ST_READY; done_d = 1'b1; end
      end
      ST_BREAK: begin
        if (expire) begin
          st_d = ST_MAKE; pl_d = pl_q - 4'd1;
          tmr_load = 1'b1; tmr_val = CNT_W'(mk_ms);
        end
      end
      ST_MAKE: begin
        if (expire) begin
          tmr_load = 1'b1;
          if (pl_q == 4'd0) begin st_d = ST_GAP; tmr_val = GAP_K; end
          else begin st_d = ST_BREAK; tmr_val = CNT_W'(brk_ms); end
        end
      end
      default: st_d = ST_ONHOOK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_ONHOOK;
      pl_q   <= '0;
      rate_q <= '0;
      done   <= 1'b0;
    end else begin
      st_q   <= st_d;
      pl_q   <= pl_d;
      rate_q <= rate_d;
      done   <= done_d;
    end
  end

  AST_HOOK_NEEDS_ISO: assert property (@(posedge clk) disable iff (!rst_n)
    relay_hook |-> relay_iso); // R7
  AST_READY_XOR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready != busy); // R12
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R5
  AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    pl_q <= 4'd10); // R3
  AST_ISO_ONLY_ON_HANGUP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(relay_iso) |-> $past(cmd_valid && cmd_ready && cmd_code == CODE_HANGUP)); // R8
  AST_RATE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_digit && $past(in_digit)) |-> $stable(rate_q)); // R10
endmodule

// File: rtl/pulse_dial_seq.sv
module pulse_dial_seq #(
  parameter int SEC_W    = 8,
  parameter int MS_PER_S = 1000,
  parameter int GAP_MS   = 700,
  parameter int FLASH_MS = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_ms,
  input  logic             cmd_valid,
  input  logic [3:0]       cmd_code,
  output logic             cmd_ready,
  input  logic [1:0]       rate_sel,
  input  logic [SEC_W-1:0] predial_s,
  input  logic [SEC_W-1:0] comma_s,
  output logic             relay_hook,
  output logic             relay_iso,
  output logic             busy,
  output logic             done
);
  localparam int CNT_W = $clog2(((2**SEC_W) - 1) * MS_PER_S + 1);
  localparam int CAD_W = 7;

  logic [1:0]       rst_sync;
  logic             rst_int_n;
  logic             expire, tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic [1:0]       cad_rate;
  logic [CAD_W-1:0] brk_ms, mk_ms;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  pd_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .tick(tick_ms),
    .load(tmr_load), .load_val(tmr_val), .expire(expire));

  pd_cadence #(.CAD_W(CAD_W)) u_cad (
    .rate(cad_rate), .brk_ms(brk_ms), .mk_ms(mk_ms));

  pd_ctrl #(.CNT_W(CNT_W), .SEC_W(SEC_W), .CAD_W(CAD_W), .MS_PER_S(MS_PER_S),
            .GAP_MS(GAP_MS), .FLASH_MS(FLASH_MS)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_ready(cmd_ready), .rate_sel(rate_sel), .predial_s(predial_s),
    .comma_s(comma_s), .expire(expire), .brk_ms(brk_ms), .mk_ms(mk_ms),
    .cad_rate(cad_rate), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .relay_hook(relay_hook), .relay_iso(relay_iso), .busy(busy), .done(done));
endmodule

// File: tb/sim_pulse_dial_seq.sv
module sim_pulse_dial_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [3:0] cmd_code = 4'd0;
  logic [1:0] rate_sel = 2'd0;
  logic [7:0] predial_s = 8'd4;
  logic [7:0] comma_s = 8'd2;
  logic       cmd_ready, relay_hook, relay_iso, busy, done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pulse_dial_seq u0 (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_en), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_ready(cmd_ready), .rate_sel(rate_sel),
    .predial_s(predial_s), .comma_s(comma_s), .relay_hook(relay_hook),
    .relay_iso(relay_iso), .busy(busy), .done(done));

  // {rate, digit code, expected pulse count}
  localparam logic [9:0] VEC [8] = '{
    {2'd0, 4'd1, 4'd1}, {2'd0, 4'd0, 4'd10}, {2'd1, 4'd3, 4'd3}, {2'd2, 4'd5, 4'd5},
    {2'd3, 4'd2, 4'd2}, {2'd2, 4'd0, 4'd10}, {2'd1, 4'd9, 4'd9}, {2'd0, 4'd7, 4'd7}};

  function automatic int exp_mk(input logic [1:0] r);
    return (r == 2'd1) ? 33 : (r == 2'd2) ? 17 : 39;
  endfunction
  function automatic int exp_brk(input logic [1:0] r);
    return ((r == 2'd2) ? 50 : 100) - exp_mk(r);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Present a command; returns at the falling edge of the cycle after acceptance.
  task automatic issue(input logic [3:0] c);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_code = c;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // Sample each cycle until done; run lengths of relay_hook.
  task automatic observe(output int falls, output int brk, output int mk,
                         output int tail, output int lows, output int busys,
                         output int isolow);
    int lo_run = 0, hi_run = 0;
    bit prev = 1'b1;
    falls = 0; brk = 0; mk = 0; tail = 0; lows = 0; busys = 0; isolow = 0;
    for (int i = 0; i < 6000; i++) begin
      if (done) break;
      if (busy) busys++;
      if (!relay_iso) isolow++;
      if (!relay_hook) begin
        lows++;
        if (prev) begin falls++; if (falls > 1) mk = hi_run; lo_run = 1; end
        else lo_run++;
      end else begin
        if (!prev) begin brk = lo_run; hi_run = 1; end
        else hi_run++;
      end
      prev = relay_hook;
      @(negedge clk);
    end
    tail = hi_run;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end

  initial begin
    int f, b, m, t, lo, bz, il;
    repeat (3) @(negedge clk);
    check("R1 hook in reset", relay_hook, 0);
    check("R1 iso in reset", relay_iso, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 hook after reset", relay_hook, 0);
    check("R1 busy/done after reset", {busy, done}, 0);
    check("R1 ready after reset", cmd_ready, 1);

    // R9: dialing while on-hook is dropped
    issue(4'd5);
    lo = 0; bz = 0;
    for (int i = 0; i < 50; i++) begin
      if (relay_hook) lo++;
      if (busy) bz++;
      @(negedge clk);
    end
    check("R9 digit on-hook hook stays 0", lo, 0);
    check("R9 digit on-hook no busy", bz, 0);

    // R2: go off-hook, 4 s predial wait
    issue(4'd12);
    check("R2 hook after off-hook", relay_hook, 1);
    check("R2 iso after off-hook", relay_iso, 1);
    observe(f, b, m, t, lo, bz, il);
    check("R2 predial busy ticks", bz, 4000);
    check("R2 done strobe", done, 1);
    @(negedge clk);
    check("R2 done one cycle", done, 0);

    // R9: repeated off-hook and spare codes ignored
    issue(4'd12);
    issue(4'd14);
    issue(4'd15);
    bz = 0;
    for (int i = 0; i < 20; i++) begin if (busy || !relay_hook) bz++; @(negedge clk); end
    check("R9 spare codes no effect", bz, 0);

    // R3/R4/R5: table of digits
    foreach (VEC[k]) begin
      rate_sel = VEC[k][9:8];
      issue(VEC[k][7:4]);
      check("R12 ready low while dialing", cmd_ready, 0);
      observe(f, b, m, t, lo, bz, il);
      check("R3 pulse count", f, int'(VEC[k][3:0]));
      check("R4 break length", b, exp_brk(VEC[k][9:8]));
      if (VEC[k][3:0] > 1) check("R4 make length", m, exp_mk(VEC[k][9:8]));
      check("R5 final make plus gap", t, exp_mk(VEC[k][9:8]) + 700);
      check("R5 ready with done", cmd_ready & done, 1);
    end

    // R10: rate change during a digit ignored
    rate_sel = 2'd0;
    issue(4'd3);
    rate_sel = 2'd2;
    observe(f, b, m, t, lo, bz, il);
    check("R10 break keeps captured rate", b, 61);
    check("R10 make keeps captured rate", m, 39);
    check("R10 pulse count", f, 3);

    // R6: pause
    issue(4'd10);
    observe(f, b, m, t, lo, bz, il);
    check("R6 pause busy ticks", bz, 2000);
    check("R6 pause hook stays 1", lo, 0);
    comma_s = 8'd0;
    issue(4'd10);
    observe(f, b, m, t, lo, bz, il);
    check("R6 zero pause single cycle", bz, 1);

    // R7: flash
    issue(4'd11);
    observe(f, b, m, t, lo, bz, il);
    check("R7 flash low ticks", lo, 500);
    check("R7 iso held during flash", il, 0);
    check("R7 hook restored", relay_hook, 1);

    // R11: tick stopped holds the phase
    tick_en = 1'b0;
    issue(4'd11);
    lo = 0;
    for (int i = 0; i < 1000; i++) begin if (!relay_hook) lo++; @(negedge clk); end
    check("R11 phase held without tick", lo, 1000);
    tick_en = 1'b1;
    observe(f, b, m, t, lo, bz, il);
    check("R11 phase resumes on tick", lo, 500);

    // R8: hang up
    issue(4'd13);
    check("R8 hook after hang up", relay_hook, 0);
    check("R8 iso after hang up", relay_iso, 0);
    check("R8 ready after hang up", cmd_ready, 1);

    // R2: zero predial
    predial_s = 8'd0;
    issue(4'd12);
    observe(f, b, m, t, lo, bz, il);
    check("R2 zero predial single cycle", bz, 1);

    summary();
  end
endmodule